// File: doc/BRIEF.md
# ADC Sample-Convert Timing Controller

This block paces one acquire-then-convert cycle of a successive-approximation converter. It derives a conversion-clock period (one "tick") in one of two ways. The first is a programmable divider on the system clock. The second is an alternate tick input, which is a one-cycle enable that is synchronous to `clk` and stands for a dedicated RC oscillator. The block holds the track phase for a programmed number of ticks, or until a selected trigger arrives. It then runs a conversion of fixed length. The analog converter itself is modelled as that fixed delay.

Four trigger sources can start a conversion: software dropping its sample bit, a rising edge on an external pin, a timer compare pulse, and an internal tick count. After a conversion, tracking can restart on its own, or it can wait for software to raise the sample bit again. Dropping the enable aborts all activity in the next cycle.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The tick period is `clk_div`+1 clock cycles when `clk_src_alt`=0. When `clk_src_alt`=1, every cycle with `alt_tick`=1 is one tick, and with `alt_tick` held at 0 nothing advances.
- R2: `result_stb` comes exactly 12 ticks after `conv_start`, which is 12*(`clk_div`+1) cycles on the divided clock.
- R3: With `trig_sel`=3'b111, `conv_start` comes max(`samp_time`,1) ticks after `sample_en` rises, so a sample time of 0 acts as 1.
- R4: With `trig_sel`=3'b000, a falling edge of `sw_samp` during tracking gives `conv_start` in the next cycle.
- R5: `trig_sel`=3'b001 starts a conversion on a rising edge of `pin_in`, and 3'b010 starts one on a `tmr_match` pulse, each with `conv_start` in the next cycle. The codes 3'b011 to 3'b110 never start a conversion, and tracking continues.
- R6: With `auto_samp`=1, `sample_en` is high in the same cycle as `result_stb`, and tracking begins as soon as the block is enabled. With `auto_samp`=0, tracking begins in the cycle after a rising edge of `sw_samp`.
- R7: `done` rises together with `result_stb` and stays high until a `done_clr` pulse, which clears it in the next cycle.
- R8: With `trig_sel`=3'b000 and `done`=1, a rising edge of `sw_samp` is ignored: `sample_en` stays low.
- R9: With `enable`=0, all outputs are low in the next cycle. A conversion that was in progress then never produces `result_stb`.
- R10: After reset, `sample_en`, `conv_start`, `result_stb` and `done` are all low.
- R11: `conv_start` and `result_stb` are one-cycle pulses, and `sample_en` is low while `conv_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Module enable; low aborts and idles |
| clk_src_alt | input | 1 | 1: ticks from `alt_tick`; 0: ticks from divider |
| alt_tick | input | 1 | Alternate tick enable, synchronous to `clk` |
| clk_div | input | 8 | Divider field; period = value+1 cycles |
| samp_time | input | 5 | Track time in ticks for the auto-count trigger |
| trig_sel | input | 3 | Trigger source code |
| auto_samp | input | 1 | Restart tracking after each conversion |
| sw_samp | input | 1 | Software sample bit (level) |
| pin_in | input | 1 | External trigger pin |
| tmr_match | input | 1 | Timer compare pulse |
| done_clr | input | 1 | Software clear of `done` |
| sample_en | output | 1 | Sample-hold in track phase |
| conv_start | output | 1 | One-cycle pulse at start of conversion |
| result_stb | output | 1 | One-cycle pulse when a result is ready |
| done | output | 1 | Sticky completion flag |

## Verification
The checker module watches every cycle for the following:
- the pulse shape of both strobes;
- `sample_en` staying low while `conv_start` is high;
- `done` being set by `result_stb` and holding until it is cleared;
- the restart decision at the end of each conversion;
- no conversion starting from a reserved trigger code;
- the exact 12-period conversion length on the divided clock.

Some behaviours can only be shown by the bench's scenarios. These are:
- the track-time arithmetic, including the substitution of 1 for 0;
- the lock-out of a software start while `done` is set;
- the abort that leaves no late result.

They need chosen configurations and stimulus sequences, and the scoreboard compares measured gaps against expected ones.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2
    } seq_state_t;

    localparam logic [2:0] TRG_SWCLR = 3'b000;
    localparam logic [2:0] TRG_PIN   = 3'b001;
    localparam logic [2:0] TRG_TIMER = 3'b010;
    localparam logic [2:0] TRG_COUNT = 3'b111;

    typedef struct packed {
        logic sw_rise;
        logic sw_fall;
        logic pin_rise;
        logic tmr;
    } trig_ev_t;

    function automatic logic is_manual(input logic [2:0] code);
        return code == TRG_SWCLR;
    endfunction

endpackage

// File: rtl/adc_tad_gen.sv
module adc_tad_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic             use_alt,
    input  logic             alt_tick,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = (cnt >= div);
    assign tick = run && (use_alt ? alt_tick : wrap);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) prev[i] <= 1'b0;
            else     prev[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev[i];
        assign fall[i] = ~sig[i] & prev[i];
    end
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
(
    input  logic [2:0] trig_sel,
    input  trig_ev_t   ev,
    input  logic       count_hit,
    output logic       fire
);
    always_comb begin
        case (trig_sel)
            TRG_SWCLR: fire = ev.sw_fall;
            TRG_PIN:   fire = ev.pin_rise;
            TRG_TIMER: fire = ev.tmr;
            TRG_COUNT: fire = count_hit;
            default:   fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int SAMP_W    = 5,
    parameter int CONV_TADS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              clk_src_alt,
    input  logic              alt_tick,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [SAMP_W-1:0] samp_time,
    input  logic [2:0]        trig_sel,
    input  logic              auto_samp,
    input  logic              sw_samp,
    input  logic              pin_in,
    input  logic              tmr_match,
    input  logic              done_clr,
    output logic              sample_en,
    output logic              conv_start,
    output logic              result_stb,
    output logic              done
);
    localparam int CONV_CW = $clog2(CONV_TADS);
    localparam logic [CONV_CW-1:0] CONV_LAST = CONV_CW'(CONV_TADS - 1);

    seq_state_t        state, nxt;
    logic              tick, restart, fire, count_hit, conv_end, allow_start;
    logic [SAMP_W-1:0] samp_cnt, samp_eff;
    logic [CONV_CW-1:0] conv_cnt;
    logic [1:0]        rise_v, fall_v;
    trig_ev_t          ev;

    adc_edge_det #(.N(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  ({pin_in, sw_samp}),
        .rise (rise_v),
        .fall (fall_v)
    );

    assign ev.sw_rise  = rise_v[0];
    assign ev.sw_fall  = fall_v[0];
    assign ev.pin_rise = rise_v[1];
    assign ev.tmr      = tmr_match;

    adc_tad_gen #(.DIV_W(DIV_W)) u_tad (
        .clk      (clk),
        .rst      (rst),
        .run      (enable),
        .restart  (restart),
        .use_alt  (clk_src_alt),
        .alt_tick (alt_tick),
        .div      (clk_div),
        .tick     (tick)
    );

    assign samp_eff  = (samp_time == '0) ? SAMP_W'(1) : samp_time;
    assign count_hit = (state == ST_SAMPLE) && tick &&
                       (({1'b0, samp_cnt} + (SAMP_W+1)'(1)) >= {1'b0, samp_eff});
    assign conv_end  = (state == ST_CONVERT) && tick && (conv_cnt == CONV_LAST);
    assign allow_start = auto_samp ||
                         (ev.sw_rise && !(is_manual(trig_sel) && done));

    adc_trig_sel u_trig (
        .trig_sel  (trig_sel),
        .ev        (ev),
        .count_hit (count_hit),
        .fire      (fire)
    );

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (allow_start) nxt = ST_SAMPLE;
            ST_SAMPLE:  if (fire)        nxt = ST_CONVERT;
            ST_CONVERT: if (conv_end)    nxt = auto_samp ? ST_SAMPLE : ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
        if (!enable) nxt = ST_IDLE;
    end

    assign restart   = (nxt != state);
    assign sample_en = (state == ST_SAMPLE);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state      <= ST_IDLE;
            samp_cnt   <= '0;
            conv_cnt   <= '0;
            conv_start <= 1'b0;
            result_stb <= 1'b0;
            done       <= 1'b0;
        end else begin
            state      <= nxt;
            conv_start <= (nxt == ST_CONVERT) && (state != ST_CONVERT);
            result_stb <= conv_end;
            if (restart)
                samp_cnt <= '0;
            else if (sample_en && tick)
                samp_cnt <= samp_cnt + SAMP_W'(1);
            if (restart)
                conv_cnt <= '0;
            else if ((state == ST_CONVERT) && tick)
                conv_cnt <= conv_cnt + CONV_CW'(1);
            if (conv_end)
                done <= 1'b1;
            else if (done_clr)
                done <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int DIV_W     = 8,
    parameter int CONV_TADS = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             clk_src_alt,
    input logic [DIV_W-1:0] clk_div,
    input logic [2:0]       trig_sel,
    input logic             auto_samp,
    input logic             done_clr,
    input logic             sample_en,
    input logic             conv_start,
    input logic             result_stb,
    input logic             done
);
    logic [DIV_W-1:0] div_q;
    logic             cfg_moved, armed;
    int unsigned      gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q     <= '0;
            cfg_moved <= 1'b1;
            armed     <= 1'b0;
            gap       <= 0;
        end else begin
            div_q <= clk_div;
            if (conv_start) begin
                gap       <= 1;
                armed     <= enable;
                cfg_moved <= clk_src_alt || (clk_div != div_q);
            end else begin
                gap <= gap + 1;
                if (clk_src_alt || (clk_div != div_q)) cfg_moved <= 1'b1;
                if (!enable) armed <= 1'b0;
            end
        end
    end

    a_r2_conv_len: assert property (@(posedge clk) disable iff (rst)
        (result_stb && armed && !cfg_moved) |-> (gap == CONV_TADS * (int'(clk_div) + 1)));

    a_r11_start_pulse: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    a_r11_stb_pulse: assert property (@(posedge clk) disable iff (rst)
        result_stb |=> !result_stb);

    a_r11_no_track_at_start: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !sample_en);

    a_r7_done_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> result_stb);

    a_r7_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !done_clr && enable) |=> done);

    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        result_stb |-> (sample_en == $past(auto_samp)));

    a_r9_abort: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!sample_en && !conv_start && !result_stb && !done));

    a_r5_reserved: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> ($past(trig_sel) inside {3'b000, 3'b001, 3'b010, 3'b111}));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .DIV_W     (DIV_W),
    .CONV_TADS (CONV_TADS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .clk_src_alt (clk_src_alt),
    .clk_div     (clk_div),
    .trig_sel    (trig_sel),
    .auto_samp   (auto_samp),
    .done_clr    (done_clr),
    .sample_en   (sample_en),
    .conv_start  (conv_start),
    .result_stb  (result_stb),
    .done        (done)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0, clk_src_alt = 1'b0, alt_tick = 1'b0;
    logic [7:0] clk_div = '0;
    logic [4:0] samp_time = '0;
    logic [2:0] trig_sel = '0;
    logic       auto_samp = 1'b0, sw_samp = 1'b0, pin_in = 1'b0;
    logic       tmr_match = 1'b0, done_clr = 1'b0;
    logic       sample_en, conv_start, result_stb, done;

    int total = 0, bad = 0;
    int cyc = 0, t_se = 0, t_cs = 0, n_cs = 0, n_stb = 0, dbl = 0;
    bit se_prev = 0, cs_prev = 0, rs_prev = 0, samp_chk = 0, finished = 0;
    int exp_conv_q[$];
    int exp_samp_q[$];

    always #4 clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst(rst), .enable(enable), .clk_src_alt(clk_src_alt),
        .alt_tick(alt_tick), .clk_div(clk_div), .samp_time(samp_time),
        .trig_sel(trig_sel), .auto_samp(auto_samp), .sw_samp(sw_samp),
        .pin_in(pin_in), .tmr_match(tmr_match), .done_clr(done_clr),
        .sample_en(sample_en), .conv_start(conv_start),
        .result_stb(result_stb), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_stb(input int target);
        while (n_stb < target) step();
    endtask

    task automatic wait_cs(input int target);
        while (n_cs < target) step();
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (sample_en && !se_prev) t_se = cyc;
            if (conv_start) begin
                n_cs++;
                if (cs_prev) dbl++;
                if (samp_chk) begin
                    if (exp_samp_q.size() == 0) check(0, "R3 unexpected start", cyc - t_se, -1);
                    else begin
                        int e;
                        e = exp_samp_q.pop_front();
                        check(cyc - t_se == e, "R3 track length", cyc - t_se, e);
                    end
                end
                t_cs = cyc;
            end
            if (result_stb) begin
                n_stb++;
                if (rs_prev) dbl++;
                if (exp_conv_q.size() == 0) check(0, "R2 unexpected result", cyc - t_cs, -1);
                else begin
                    int e;
                    e = exp_conv_q.pop_front();
                    check(cyc - t_cs == e, "R2 conversion length", cyc - t_cs, e);
                end
            end
            se_prev = sample_en;
            cs_prev = conv_start;
            rs_prev = result_stb;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R10 reset state
        check({sample_en, conv_start, result_stb, done} == 4'b0, "R10 reset outputs",
              {sample_en, conv_start, result_stb, done}, 0);

        // auto-count trigger, divided clock, auto restart (R1 R2 R3 R6)
        clk_div = 8'd2; samp_time = 5'd3; trig_sel = 3'b111; auto_samp = 1'b1;
        samp_chk = 1;
        exp_samp_q.push_back(9); exp_samp_q.push_back(9);
        exp_conv_q.push_back(36); exp_conv_q.push_back(36);
        base = n_stb;
        enable = 1'b1;
        wait_stb(base + 2);
        check(sample_en == 1'b1, "R6 auto restart with result", sample_en, 1);
        check(done == 1'b1, "R7 done with result", done, 1);
        enable = 1'b0;
        step();
        check({sample_en, conv_start, result_stb, done} == 4'b0, "R9 disable clears",
              {sample_en, conv_start, result_stb, done}, 0);
        check(exp_samp_q.size() == 0, "R3 all tracks seen", exp_samp_q.size(), 0);

        // zero sample time acts as one (R3)
        clk_div = 8'd1; samp_time = 5'd0;
        exp_samp_q.push_back(2); exp_conv_q.push_back(24);
        base = n_stb;
        enable = 1'b1;
        wait_stb(base + 1);
        enable = 1'b0;
        step();
        check(exp_samp_q.size() == 0, "R3 zero treated as one", exp_samp_q.size(), 0);

        // alternate tick source (R1)
        clk_src_alt = 1'b1; alt_tick = 1'b1; samp_time = 5'd4; clk_div = 8'd9;
        exp_samp_q.push_back(4); exp_conv_q.push_back(12);
        base = n_stb;
        enable = 1'b1;
        wait_stb(base + 1);
        enable = 1'b0;
        step();
        alt_tick = 1'b0;
        base = n_cs;
        enable = 1'b1;
        repeat (50) step();
        check(n_cs == base, "R1 idle alt tick stalls", n_cs, base);
        check(sample_en == 1'b1, "R1 still tracking", sample_en, 1);
        enable = 1'b0;
        step();
        samp_chk = 0;
        clk_src_alt = 1'b0;
        exp_samp_q.delete();

        // manual mode (R4 R6 R7 R8)
        clk_div = 8'd0; trig_sel = 3'b000; auto_samp = 1'b0;
        enable = 1'b1;
        step(); step();
        check(sample_en == 1'b0, "R6 no auto track", sample_en, 0);
        sw_samp = 1'b1;
        step();
        check(sample_en == 1'b1, "R6 sw rise starts track", sample_en, 1);
        repeat (5) step();
        base = n_cs;
        exp_conv_q.push_back(12);
        sw_samp = 1'b0;
        step();
        check(n_cs == base + 1, "R4 sw fall starts conversion", n_cs, base + 1);
        wait_stb(n_stb + 1);
        check(done == 1'b1, "R7 done set", done, 1);
        repeat (10) step();
        check(done == 1'b1, "R7 done holds", done, 1);
        sw_samp = 1'b1;
        step(); step();
        check(sample_en == 1'b0, "R8 start blocked while done", sample_en, 0);
        sw_samp = 1'b0; done_clr = 1'b1;
        step();
        done_clr = 1'b0;
        check(done == 1'b0, "R7 done cleared", done, 0);
        sw_samp = 1'b1;
        step();
        check(sample_en == 1'b1, "R8 start after clear", sample_en, 1);

        // pin trigger while tracking (R5)
        trig_sel = 3'b001;
        base = n_cs;
        exp_conv_q.push_back(12);
        pin_in = 1'b1;
        step();
        pin_in = 1'b0;
        check(n_cs == base + 1, "R5 pin edge starts", n_cs, base + 1);
        wait_stb(n_stb + 1);
        sw_samp = 1'b0;
        step();

        // timer trigger (R5)
        trig_sel = 3'b010;
        sw_samp = 1'b1;
        step();
        base = n_cs;
        exp_conv_q.push_back(12);
        tmr_match = 1'b1;
        step();
        tmr_match = 1'b0;
        check(n_cs == base + 1, "R5 timer pulse starts", n_cs, base + 1);
        wait_stb(n_stb + 1);
        sw_samp = 1'b0;
        step();

        // reserved code (R5)
        trig_sel = 3'b011;
        sw_samp = 1'b1;
        step();
        base = n_cs;
        pin_in = 1'b1; tmr_match = 1'b1;
        step();
        pin_in = 1'b0; tmr_match = 1'b0; sw_samp = 1'b0;
        repeat (30) step();
        check(n_cs == base, "R5 reserved never starts", n_cs, base);
        check(sample_en == 1'b1, "R5 reserved keeps tracking", sample_en, 1);
        enable = 1'b0;
        step();

        // abort mid conversion (R9)
        trig_sel = 3'b111; samp_time = 5'd1; clk_div = 8'd3;
        enable = 1'b1;
        base = n_cs;
        sw_samp = 1'b1;
        wait_cs(base + 1);
        repeat (10) step();
        enable = 1'b0;
        step();
        check({sample_en, conv_start, result_stb, done} == 4'b0, "R9 abort clears",
              {sample_en, conv_start, result_stb, done}, 0);
        base = n_stb;
        repeat (60) step();
        check(n_stb == base, "R9 no late result", n_stb, base);
        sw_samp = 1'b0;

        check(dbl == 0, "R11 single-cycle strobes", dbl, 0);
        check(exp_conv_q.size() == 0, "R2 all results seen", exp_conv_q.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule